// File: doc/BRIEF.md
# HDLC Receive FIFO Frame Manager

This block sits between a receive deframer and a host processor. The deframer delivers one byte per cycle, marking the first and last byte of each frame. The block stores those bytes in a 32-byte ring made of two 16-byte halves. It signals the host when a frame has progressed far enough to be trusted, when a half of the ring is full, and when a frame has ended. The host pulls bytes out through a read strobe. Space is returned to the ring only when the host explicitly confirms that it has finished with what it read.

A new frame is admitted only if the ring holds no unreleased bytes. A frame that meets an occupied ring is thrown away in full, and the loss is reported. The host drives the block through a write-only command byte:
- one bit releases the bytes read so far;
- another bit wipes the ring and the frame state.

Each command takes a fixed number of cycles to act. While it is pending, a busy flag is raised and further writes are refused. Every interrupt is a one-cycle pulse, and each one is also latched into a status vector that clears when read.

Top module: `rx_frame_fifo`

## Requirements
- R1: After reset, `fifo_level` is 0, `cmd_busy` is 0, `isr_q` is 0 and all four interrupt pulses are low.
- R2: A byte flagged `rx_sof` is admitted only when `fifo_level` is 0. The admitted frame's bytes are stored, and the host reads them back on `rd_data` in arrival order. Each `rd_en` cycle advances to the next byte while unread bytes exist.
- R3: A frame whose `rx_sof` byte arrives while `fifo_level` is not 0 is discarded whole. `irq_ovf` pulses once, the cycle after that byte, and `fifo_level` is unchanged.
- R4: `irq_start` pulses the cycle after the third byte of an admitted frame is stored. It fires only when `start_ie` is 1. A frame of fewer than three bytes gives no pulse.
- R5: `irq_pool` pulses the cycle after a byte is stored into the last slot of either half. The slots are ring positions 15 and 31, counted from 0 after reset or a wipe.
- R6: `irq_end` pulses the cycle after the `rx_eof` byte of an admitted frame is stored.
- R7: A byte of an admitted frame that arrives while 32 bytes are held is dropped and raises `irq_ovf`. The rest of that frame is dropped, and it produces no `irq_end`.
- R8: A command write with bit 7 set releases the bytes read so far, lowering `fifo_level` by that count. It takes effect at the second clock edge after the write is captured.
- R9: A command write with bit 6 set makes `fifo_level` 0 and resets the read and write positions. The remaining bytes of a frame in progress are discarded.
- R10: `cmd_busy` is 1 for exactly two cycles after a command write is captured. A command write made while `cmd_busy` is 1 is ignored.
- R11: `isr_q` latches the pulses as bit 0 start, bit 1 pool, bit 2 end and bit 3 overflow. A cycle with `isr_rd` high clears the bits, but a pulse in that same cycle still sets its bit.
- R12: A release that executes in the same cycle as a stored byte keeps both effects. `fifo_level` becomes the old level plus one, minus the count released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Receive byte present this cycle |
| rx_data | input | 8 | Receive byte |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_eof | input | 1 | Byte is the last of a frame |
| start_ie | input | 1 | Enable for the frame-start interrupt |
| cmd_we | input | 1 | Command byte write strobe |
| cmd_wdata | input | 8 | Command byte (bit 7 release, bit 6 wipe) |
| cmd_busy | output | 1 | Command pending, writes refused |
| rd_en | input | 1 | Host read strobe, advances the read position |
| rd_data | output | 8 | Byte at the read position |
| fifo_level | output | 6 | Bytes stored and not yet released |
| isr_rd | input | 1 | Host read of the status vector, clears it |
| isr_q | output | 4 | Latched interrupt status |
| irq_start | output | 1 | Frame-start pulse |
| irq_pool | output | 1 | Half-full pulse |
| irq_end | output | 1 | Frame-end pulse |
| irq_ovf | output | 1 | Dropped-frame pulse |

## Verification
The risky collision is a release command reaching its execution edge in the same cycle as a deframer byte being written. Both then update the occupancy arithmetic at once. The bench reads one byte and writes the release command. It places the next frame byte exactly two edges later, so the write and the release land together. It then expects the level to equal the earlier level plus one minus one. A lost write or a lost release would each leave a different, wrong count.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

   localparam int unsigned CMD_W       = 8;
   localparam int unsigned CMD_REL_BIT = 7;
   localparam int unsigned CMD_CLR_BIT = 6;
   localparam int unsigned IRQ_N       = 4;

   typedef struct packed {
      logic ovf;
      logic fin;
      logic pool;
      logic start;
   } rxf_irq_t;

endpackage

// File: rtl/rxf_cmd.sv
module rxf_cmd
   import rxf_pkg::*;
#(
   parameter int unsigned CMD_LAT = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_we,
   input  logic [CMD_W-1:0] cmd_wdata,
   output logic             busy,
   output logic             do_release,
   output logic             do_clear
);

   logic pend_rel_q, pend_clr_q, exec;
   logic take;
   logic unused_cmd_bits;

   assign unused_cmd_bits = ^cmd_wdata;
   assign take            = cmd_we && !busy;

   generate
      if (CMD_LAT == 1) begin : g_lat_one
         assign exec = busy;
      end else begin : g_lat_cnt
         localparam int unsigned CNTW = $clog2(CMD_LAT);
         logic [CNTW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                    cnt_q <= '0;
            else if (take)                 cnt_q <= CNTW'(CMD_LAT - 1);
            else if (busy && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
         end
         assign exec = busy && (cnt_q == '0);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy       <= 1'b0;
         pend_rel_q <= 1'b0;
         pend_clr_q <= 1'b0;
      end else if (take) begin
         busy       <= 1'b1;
         pend_rel_q <= cmd_wdata[CMD_REL_BIT];
         pend_clr_q <= cmd_wdata[CMD_CLR_BIT];
      end else if (exec) begin
         busy       <= 1'b0;
      end
   end

   assign do_release = exec && pend_rel_q;
   assign do_clear   = exec && pend_clr_q;

endmodule

// File: rtl/rxf_store.sv
module rxf_store #(
   parameter int unsigned DW    = 8,
   parameter int unsigned DEPTH = 32,
   localparam int unsigned AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_en,
   input  logic          release_rd,
   output logic [DW-1:0] rd_data,
   output logic [AW:0]   level,
   output logic          level_zero,
   output logic          full,
   output logic          half_end
);

   logic [DW-1:0] mem [DEPTH];
   logic [AW:0]   wp_q, rp_q, fp_q;

   always_ff @(posedge clk) begin
      if (wr_en) mem[wp_q[AW-1:0]] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q <= '0;
         rp_q <= '0;
         fp_q <= '0;
      end else if (clr) begin
         wp_q <= '0;
         rp_q <= '0;
         fp_q <= '0;
      end else begin
         if (wr_en)                  wp_q <= wp_q + 1'b1;
         if (rd_en && rp_q != wp_q)  rp_q <= rp_q + 1'b1;
         if (release_rd)             fp_q <= rp_q;
      end
   end

   assign rd_data    = mem[rp_q[AW-1:0]];
   assign level      = wp_q - fp_q;
   assign level_zero = (level == '0);
   assign full       = (level == (AW+1)'(DEPTH));
   assign half_end   = &wp_q[AW-2:0];

endmodule

// File: rtl/rxf_frame.sv
module rxf_frame
   import rxf_pkg::*;
#(
   parameter int unsigned START_SKIP = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     clr,
   input  logic     rx_valid,
   input  logic     rx_sof,
   input  logic     rx_eof,
   input  logic     start_ie,
   input  logic     level_zero,
   input  logic     full,
   input  logic     half_end,
   output logic     wr_en,
   output rxf_irq_t irq
);

   localparam int unsigned CW = $clog2(START_SKIP + 2);
   localparam logic [CW-1:0] CNT_SAT = CW'(START_SKIP + 1);

   logic          in_frame_q;
   logic [CW-1:0] cnt_q, cnt_now;
   logic          ovf_now;
   rxf_irq_t      irq_d;

   assign cnt_now = rx_sof ? '0 : cnt_q;
   assign wr_en   = !clr && rx_valid && (rx_sof ? level_zero : (in_frame_q && !full));
   assign ovf_now = !clr && rx_valid && (rx_sof ? !level_zero : (in_frame_q && full));

   always_comb begin
      irq_d       = '0;
      irq_d.start = wr_en && start_ie && (cnt_now == CW'(START_SKIP));
      irq_d.pool  = wr_en && half_end;
      irq_d.fin   = wr_en && rx_eof;
      irq_d.ovf   = ovf_now;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_frame_q <= 1'b0;
         cnt_q      <= '0;
         irq        <= '0;
      end else begin
         irq <= irq_d;
         if (clr) begin
            in_frame_q <= 1'b0;
            cnt_q      <= '0;
         end else if (wr_en) begin
            in_frame_q <= !rx_eof;
            cnt_q      <= (cnt_now == CNT_SAT) ? CNT_SAT : cnt_now + 1'b1;
         end else if (ovf_now) begin
            in_frame_q <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/rxf_isr.sv
module rxf_isr #(
   parameter int unsigned N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic         rd,
   output logic [N-1:0] q
);

   generate
      for (genvar i = 0; i < N; i++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q[i] <= 1'b0;
            else        q[i] <= set[i] | (q[i] & ~rd);
         end
      end
   endgenerate

endmodule

// File: rtl/rx_frame_fifo.sv
module rx_frame_fifo
   import rxf_pkg::*;
#(
   parameter int unsigned DW         = 8,
   parameter int unsigned DEPTH      = 32,
   parameter int unsigned CMD_LAT    = 2,
   parameter int unsigned START_SKIP = 2,
   localparam int unsigned AW        = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_valid,
   input  logic [DW-1:0]    rx_data,
   input  logic             rx_sof,
   input  logic             rx_eof,
   input  logic             start_ie,
   input  logic             cmd_we,
   input  logic [CMD_W-1:0] cmd_wdata,
   output logic             cmd_busy,
   input  logic             rd_en,
   output logic [DW-1:0]    rd_data,
   output logic [AW:0]      fifo_level,
   input  logic             isr_rd,
   output logic [IRQ_N-1:0] isr_q,
   output logic             irq_start,
   output logic             irq_pool,
   output logic             irq_end,
   output logic             irq_ovf
);

   generate
      if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("rx_frame_fifo: DEPTH must be a power of two of at least 4");
      end
      if (CMD_LAT < 1) begin : g_bad_lat
         $error("rx_frame_fifo: CMD_LAT must be at least 1");
      end
      if (START_SKIP < 1) begin : g_bad_skip
         $error("rx_frame_fifo: START_SKIP must be at least 1");
      end
   endgenerate

   logic     do_release, do_clear;
   logic     wr_en, level_zero, full, half_end;
   rxf_irq_t irq;

   rxf_cmd #(.CMD_LAT(CMD_LAT)) u_cmd (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_we     (cmd_we),
      .cmd_wdata  (cmd_wdata),
      .busy       (cmd_busy),
      .do_release (do_release),
      .do_clear   (do_clear)
   );

   rxf_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (do_clear),
      .wr_en      (wr_en),
      .wr_data    (rx_data),
      .rd_en      (rd_en),
      .release_rd (do_release),
      .rd_data    (rd_data),
      .level      (fifo_level),
      .level_zero (level_zero),
      .full       (full),
      .half_end   (half_end)
   );

   rxf_frame #(.START_SKIP(START_SKIP)) u_frame (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (do_clear),
      .rx_valid   (rx_valid),
      .rx_sof     (rx_sof),
      .rx_eof     (rx_eof),
      .start_ie   (start_ie),
      .level_zero (level_zero),
      .full       (full),
      .half_end   (half_end),
      .wr_en      (wr_en),
      .irq        (irq)
   );

   rxf_isr #(.N(IRQ_N)) u_isr (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (irq),
      .rd    (isr_rd),
      .q     (isr_q)
   );

   assign irq_start = irq.start;
   assign irq_pool  = irq.pool;
   assign irq_end   = irq.fin;
   assign irq_ovf   = irq.ovf;

endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
   parameter int unsigned DEPTH = 32,
   localparam int unsigned AW   = $clog2(DEPTH)
) (
   input logic        clk,
   input logic        rst_n,
   input logic        rx_valid,
   input logic        rx_eof,
   input logic        start_ie,
   input logic        cmd_we,
   input logic        cmd_busy,
   input logic [AW:0] fifo_level,
   input logic        isr_rd,
   input logic [3:0]  isr_q,
   input logic        irq_start,
   input logic        irq_pool,
   input logic        irq_end,
   input logic        irq_ovf
);

   a_r1_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
      int'(fifo_level) <= int'(DEPTH));

   a_r2_level_step: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> int'(fifo_level) <= int'($past(fifo_level)) + 1);

   a_r3_ovf_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ovf |-> $past(rx_valid));

   a_r4_start_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      irq_start |-> $past(start_ie && rx_valid));

   a_r5_pool_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pool |-> $past(rx_valid));

   a_r6_end_needs_eof: assert property (@(posedge clk) disable iff (!rst_n)
      irq_end |-> $past(rx_valid && rx_eof));

   a_r10_busy_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_we && !cmd_busy) |=> cmd_busy);

   a_r11_isr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !isr_rd |=> ((isr_q & $past(isr_q)) == $past(isr_q)));

endmodule

bind rx_frame_fifo rxf_checker #(.DEPTH(DEPTH)) u_rxf_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .rx_valid   (rx_valid),
   .rx_eof     (rx_eof),
   .start_ie   (start_ie),
   .cmd_we     (cmd_we),
   .cmd_busy   (cmd_busy),
   .fifo_level (fifo_level),
   .isr_rd     (isr_rd),
   .isr_q      (isr_q),
   .irq_start  (irq_start),
   .irq_pool   (irq_pool),
   .irq_end    (irq_end),
   .irq_ovf    (irq_ovf)
);

// File: tb/tb_rx_frame_fifo.sv
module tb_rx_frame_fifo;

   localparam int DEPTH   = 32;
   localparam int CMD_LAT = 2;
   localparam int N_VEC   = 6;
   localparam int V_LEN   [N_VEC] = '{1, 2, 3, 5, 16, 20};
   localparam bit V_IE    [N_VEC] = '{1, 1, 1, 0, 1, 1};
   localparam int V_START [N_VEC] = '{0, 0, 1, 0, 1, 1};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, start_ie = 1'b1;
   logic [7:0] rx_data = '0;
   logic       cmd_we = 1'b0;
   logic [7:0] cmd_wdata = '0;
   logic       rd_en = 1'b0, isr_rd = 1'b0;
   logic       cmd_busy;
   logic [7:0] rd_data;
   logic [5:0] fifo_level;
   logic [3:0] isr_q;
   logic       irq_start, irq_pool, irq_end, irq_ovf;

   int n_run = 0, n_fail = 0;
   int c_start = 0, c_pool = 0, c_end = 0, c_ovf = 0;
   int wpos = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   rx_frame_fifo dut (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
      .rx_sof(rx_sof), .rx_eof(rx_eof), .start_ie(start_ie),
      .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .cmd_busy(cmd_busy),
      .rd_en(rd_en), .rd_data(rd_data), .fifo_level(fifo_level),
      .isr_rd(isr_rd), .isr_q(isr_q), .irq_start(irq_start),
      .irq_pool(irq_pool), .irq_end(irq_end), .irq_ovf(irq_ovf)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         c_start += int'(irq_start);
         c_pool  += int'(irq_pool);
         c_end   += int'(irq_end);
         c_ovf   += int'(irq_ovf);
      end
   end

   function automatic logic [7:0] pat(input int tag, input int i);
      return 8'((tag * 16 + i) ^ 8'h5A);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // drives n bytes starting at index first; sets wpos for stored bytes
   task automatic send(input int tag, input int first, input int n,
                       input bit sof_first, input bit eof_last, input int store_n);
      for (int i = 0; i < n; i++) begin
         rx_valid = 1'b1;
         rx_data  = pat(tag, first + i);
         rx_sof   = sof_first && (i == 0);
         rx_eof   = eof_last && (i == n - 1);
         @(negedge clk);
      end
      rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
      wpos += store_n;
      repeat (2) @(negedge clk);
   endtask

   task automatic read_chk(input int tag, input int first, input int n, input string req);
      int bad = 0;
      int last_act = 0, last_exp = 0;
      for (int i = 0; i < n; i++) begin
         rd_en = 1'b1;
         if (rd_data !== pat(tag, first + i)) begin
            bad++;
            last_act = int'(rd_data);
            last_exp = int'(pat(tag, first + i));
         end
         @(negedge clk);
      end
      rd_en = 1'b0;
      chk(bad == 0, req, last_act, last_exp);
   endtask

   task automatic cmd(input logic [7:0] v);
      while (cmd_busy) @(negedge clk);
      cmd_we = 1'b1; cmd_wdata = v;
      @(negedge clk);
      cmd_we = 1'b0; cmd_wdata = '0;
      repeat (CMD_LAT) @(negedge clk);
   endtask

   task automatic read_isr(output logic [3:0] v);
      v = isr_q;
      isr_rd = 1'b1;
      @(negedge clk);
      isr_rd = 1'b0;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin : main
      int s0, p0, e0, o0, exp_pool;
      logic [3:0] iv;

      repeat (3) @(negedge clk);
      // R1 reset state
      chk(fifo_level == 0, "R1 level", int'(fifo_level), 0);
      chk(cmd_busy == 0, "R1 busy", int'(cmd_busy), 0);
      chk(isr_q == 0, "R1 isr", int'(isr_q), 0);
      chk({irq_start, irq_pool, irq_end, irq_ovf} == 0, "R1 irq",
          int'({irq_start, irq_pool, irq_end, irq_ovf}), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // vector table: R2 R4 R5 R6 R8
      for (int v = 0; v < N_VEC; v++) begin
         start_ie = V_IE[v];
         exp_pool = 0;
         for (int i = 0; i < V_LEN[v]; i++)
            if (((wpos + i) % 16) == 15) exp_pool++;
         s0 = c_start; p0 = c_pool; e0 = c_end;
         send(v, 0, V_LEN[v], 1'b1, 1'b1, V_LEN[v]);
         chk(c_start - s0 == V_START[v], "R4 start pulses", c_start - s0, V_START[v]);
         chk(c_pool - p0 == exp_pool, "R5 pool pulses", c_pool - p0, exp_pool);
         chk(c_end - e0 == 1, "R6 end pulse", c_end - e0, 1);
         chk(int'(fifo_level) == V_LEN[v], "R2 level", int'(fifo_level), V_LEN[v]);
         read_chk(v, 0, V_LEN[v], "R2 data order");
         cmd(8'h80);
         chk(fifo_level == 0, "R8 release", int'(fifo_level), 0);
      end
      start_ie = 1'b1;

      // R11 latch and clear
      read_isr(iv);
      chk(iv == 4'b0111, "R11 latched", int'(iv), 7);
      chk(isr_q == 0, "R11 cleared", int'(isr_q), 0);

      // R3 whole-frame drop while occupied
      send(10, 0, 2, 1'b1, 1'b1, 2);
      s0 = c_start; e0 = c_end; o0 = c_ovf;
      send(11, 0, 3, 1'b1, 1'b1, 0);
      chk(c_ovf - o0 == 1, "R3 ovf pulse", c_ovf - o0, 1);
      chk(c_start - s0 == 0 && c_end - e0 == 0, "R3 no frame irq", c_start - s0 + c_end - e0, 0);
      chk(fifo_level == 2, "R3 level kept", int'(fifo_level), 2);
      read_isr(iv);
      chk(iv[3] == 1'b1, "R11 ovf bit", int'(iv[3]), 1);

      // R8 latency and R10 busy / ignored write
      read_chk(10, 0, 1, "R2 partial read");
      cmd_we = 1'b1; cmd_wdata = 8'h80;
      @(negedge clk);
      chk(cmd_busy == 1, "R10 busy set", int'(cmd_busy), 1);
      chk(fifo_level == 2, "R8 not yet", int'(fifo_level), 2);
      cmd_wdata = 8'h40;
      @(negedge clk);
      cmd_we = 1'b0; cmd_wdata = '0;
      chk(cmd_busy == 1 && fifo_level == 2, "R8 second cycle", int'(fifo_level), 2);
      @(negedge clk);
      chk(fifo_level == 1, "R8 executed", int'(fifo_level), 1);
      chk(cmd_busy == 0, "R10 busy cleared", int'(cmd_busy), 0);
      repeat (4) @(negedge clk);
      chk(fifo_level == 1, "R10 write ignored", int'(fifo_level), 1);
      read_chk(10, 1, 1, "R2 tail read");
      cmd(8'h80);

      // R12 release and write in the same cycle
      send(12, 0, 1, 1'b1, 1'b0, 1);
      read_chk(12, 0, 1, "R12 first byte");
      cmd_we = 1'b1; cmd_wdata = 8'h80;
      @(negedge clk);
      cmd_we = 1'b0; cmd_wdata = '0;
      @(negedge clk);
      e0 = c_end;
      rx_valid = 1'b1; rx_data = pat(12, 1); rx_eof = 1'b1;
      @(negedge clk);
      rx_valid = 1'b0; rx_eof = 1'b0;
      wpos += 1;
      chk(fifo_level == 1, "R12 both applied", int'(fifo_level), 1);
      repeat (2) @(negedge clk);
      chk(c_end - e0 == 1, "R12 end pulse", c_end - e0, 1);
      read_chk(12, 1, 1, "R12 second byte");
      cmd(8'h80);

      // R7 full mid-frame
      e0 = c_end; o0 = c_ovf;
      send(13, 0, 34, 1'b1, 1'b1, 32);
      chk(fifo_level == 32, "R7 level full", int'(fifo_level), 32);
      chk(c_ovf - o0 == 1, "R7 ovf pulse", c_ovf - o0, 1);
      chk(c_end - e0 == 0, "R7 no end", c_end - e0, 0);

      // R9 wipe, including a frame in progress
      cmd(8'h40);
      wpos = 0;
      chk(fifo_level == 0, "R9 wiped", int'(fifo_level), 0);
      send(14, 0, 3, 1'b1, 1'b0, 3);
      cmd(8'h40);
      wpos = 0;
      e0 = c_end;
      send(14, 3, 2, 1'b0, 1'b1, 0);
      chk(fifo_level == 0, "R9 remainder dropped", int'(fifo_level), 0);
      chk(c_end - e0 == 0, "R9 no end", c_end - e0, 0);
      send(15, 0, 3, 1'b1, 1'b1, 3);
      chk(fifo_level == 3, "R9 fresh frame", int'(fifo_level), 3);
      read_chk(15, 0, 3, "R9 positions reset");

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule